// File: doc/BRIEF.md
# Dynamic Pixel Depth Expander

This block widens the colour components of a pixel stream to a fixed 12-bit width, so that the logic behind it only ever deals with one component width. An upstream stage delivers pixels whose components carry 8 or 10 significant bits, left-aligned in 12-bit fields. A single mode bit says which of the two source widths is in use. When expansion is allowed, the vacated low-order bits are refilled by repeating the most significant bits of the component. This maps full-scale input to full-scale output and zero to zero.

Expansion is permitted only when a software-controlled enable is set and the attached link is one of three digital link types: HDMI, DisplayPort, or DisplayPort multi-stream. On any other link, or with the enable clear, the significant bits still pass through, but the low-order bits are filled with zeros. Source data with a true 12-bit depth is sent through the 10-bit mode with expansion on. The two lowest input bits are then replaced by the repeated top bits.

All three components go through identical, parallel lanes. The result is registered, giving a fixed one-cycle latency. The valid flag travels through the same register stage as the data.

Top module: `dpx_expander`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and every bit of `out_pix` are cleared to zero at that edge.
- R2: `out_valid` equals the `in_valid` of the previous clock cycle, and a pixel accepted with `in_valid` high appears on `out_pix` after exactly one clock edge.
- R3: Component k occupies bits `[12k+11:12k]` of both `in_pix` and `out_pix`. The output's top bits copy the input's top bits unchanged: `[11:2]` in mode 0 (`exp_mode`=0, 10-bit source) and `[11:4]` in mode 1 (`exp_mode`=1, 8-bit source).
- R4: In mode 0, with expansion permitted, output bits `[1:0]` of each component equal input bits `[11:10]`.
- R5: In mode 1, with expansion permitted, output bits `[3:0]` of each component equal input bits `[11:8]`.
- R6: Expansion is permitted only for link codes 2 (HDMI), 3 (DisplayPort) and 4 (DisplayPort multi-stream). Codes 0, 1, 5, 6 and 7 force the low bits to zero even when `exp_en` is 1.
- R7: With `exp_en` = 0, the low bits (`[1:0]` in mode 0, `[3:0]` in mode 1) are zero for every link code.
- R8: A 12-bit source sent in mode 0 with expansion permitted has its input bits `[1:0]` ignored. They are replaced by input bits `[11:10]`. Likewise, input bits below the source width never reach the output in either mode.
- R9: Each component is expanded from its own field only. Different values in the three components yield three independently correct results.
- R10: In a cycle where `in_valid` is low, `out_pix` keeps its previous value at the next edge, whatever `in_pix` and the control inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_pix | input | 36 | Three left-aligned 12-bit components, component 0 in the low field |
| exp_en | input | 1 | Expansion enable |
| exp_mode | input | 1 | 0: 10-bit source, 1: 8-bit source |
| link_type | input | 3 | Attached link code (2 HDMI, 3 DisplayPort, 4 DisplayPort multi-stream, others non-qualifying) |
| out_valid | output | 1 | Output pixel qualifier |
| out_pix | output | 36 | Three 12-bit expanded components |

## Verification
The checker observes every cycle and every component lane. On each cycle it confirms that the valid flag is delayed by one cycle, that the data holds while the input is idle, and that the significant bits pass through in both modes. It also checks that the low bits hold either the repeated top bits or zeros, depending on the enable and the link code. Only the bench's scenarios show certain other behaviours. These include the cleared state coming out of reset and the sweep of all eight link codes. They also include the replacement of genuine 12-bit low bits, and three components with unrelated values processed in one beat. Each of these is checked against values the bench works out for itself.

// File: rtl/dpx_pkg.sv
package dpx_pkg;

  // Link codes seen on link_type
  typedef enum logic [2:0] {
    LINK_DVI_SINGLE = 3'd0,
    LINK_DVI_DUAL   = 3'd1,
    LINK_HDMI       = 3'd2,
    LINK_DP         = 3'd3,
    LINK_DP_MULTI   = 3'd4,
    LINK_LVDS       = 3'd5,
    LINK_ANALOG     = 3'd6,
    LINK_NONE       = 3'd7
  } link_code_e;

  // Source width selected by exp_mode
  typedef enum logic {
    SRC_TEN   = 1'b0,
    SRC_EIGHT = 1'b1
  } src_width_e;

  function automatic logic link_qualifies(input logic [2:0] code);
    unique case (link_code_e'(code))
      LINK_HDMI, LINK_DP, LINK_DP_MULTI: link_qualifies = 1'b1;
      default:                           link_qualifies = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dpx_ctrl_decode.sv
module dpx_ctrl_decode
  import dpx_pkg::*;
#(
  parameter int LINK_W = 3
) (
  input  logic              exp_en,
  input  logic              exp_mode,
  input  logic [LINK_W-1:0] link_type,
  output logic              repl_on,
  output src_width_e        src_sel
);

  logic link_ok;

  always_comb begin
    link_ok = link_qualifies(3'(link_type));
    repl_on = exp_en & link_ok;
    src_sel = src_width_e'(exp_mode);
  end

endmodule

// File: rtl/dpx_widen.sv
// Widens one left-aligned source of SRC_W bits to OUT_W bits, refilling the
// gap with the source MSBs (repeated cyclically) or zeros.
module dpx_widen #(
  parameter int SRC_W = 10,
  parameter int OUT_W = 12
) (
  input  logic [SRC_W-1:0] src,
  input  logic             repl_on,
  output logic [OUT_W-1:0] wide
);

  localparam int GAP = OUT_W - SRC_W;

  logic [GAP-1:0] fill;

  for (genvar i = 0; i < GAP; i++) begin : g_fill
    localparam int SRC_IDX = SRC_W - 1 - ((GAP - 1 - i) % SRC_W);
    assign fill[i] = src[SRC_IDX];
  end

  always_comb begin
    wide = {src, (repl_on ? fill : {GAP{1'b0}})};
  end

endmodule

// File: rtl/dpx_lane.sv
module dpx_lane
  import dpx_pkg::*;
#(
  parameter int OUT_W    = 12,
  parameter int WIDE_W   = 10,
  parameter int NARROW_W = 8
) (
  input  logic [OUT_W-1:0] comp_in,
  input  logic             repl_on,
  input  src_width_e       src_sel,
  output logic [OUT_W-1:0] comp_out
);

  localparam int LOW_UNUSED = OUT_W - WIDE_W;

  logic [OUT_W-1:0] from_wide;
  logic [OUT_W-1:0] from_narrow;
  logic [LOW_UNUSED-1:0] unused_low;

  // Bits below the wider source never carry data into the result
  assign unused_low = comp_in[LOW_UNUSED-1:0];

  dpx_widen #(.SRC_W(WIDE_W), .OUT_W(OUT_W)) u_wide (
    .src     (comp_in[OUT_W-1 -: WIDE_W]),
    .repl_on (repl_on),
    .wide    (from_wide)
  );

  dpx_widen #(.SRC_W(NARROW_W), .OUT_W(OUT_W)) u_narrow (
    .src     (comp_in[OUT_W-1 -: NARROW_W]),
    .repl_on (repl_on),
    .wide    (from_narrow)
  );

  always_comb begin
    unique case (src_sel)
      SRC_EIGHT: comp_out = from_narrow;
      default:   comp_out = from_wide;
    endcase
  end

endmodule

// File: rtl/dpx_expander.sv
module dpx_expander
  import dpx_pkg::*;
#(
  parameter int NUM_COMP = 3,
  parameter int OUT_W    = 12,
  parameter int WIDE_W   = 10,
  parameter int NARROW_W = 8,
  parameter int LINK_W   = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [NUM_COMP*OUT_W-1:0] in_pix,
  input  logic                      exp_en,
  input  logic                      exp_mode,
  input  logic [LINK_W-1:0]         link_type,
  output logic                      out_valid,
  output logic [NUM_COMP*OUT_W-1:0] out_pix
);

  localparam int PIX_W = NUM_COMP * OUT_W;

  logic             repl_on;
  src_width_e       src_sel;
  logic [PIX_W-1:0] lane_pix;

  dpx_ctrl_decode #(.LINK_W(LINK_W)) u_ctrl (
    .exp_en    (exp_en),
    .exp_mode  (exp_mode),
    .link_type (link_type),
    .repl_on   (repl_on),
    .src_sel   (src_sel)
  );

  for (genvar k = 0; k < NUM_COMP; k++) begin : g_lane
    dpx_lane #(
      .OUT_W    (OUT_W),
      .WIDE_W   (WIDE_W),
      .NARROW_W (NARROW_W)
    ) u_lane (
      .comp_in  (in_pix[k*OUT_W +: OUT_W]),
      .repl_on  (repl_on),
      .src_sel  (src_sel),
      .comp_out (lane_pix[k*OUT_W +: OUT_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_pix <= lane_pix;
    end
  end

endmodule

// File: rtl/dpx_expander_chk.sv
module dpx_expander_chk #(
  parameter int NUM_COMP = 3,
  parameter int OUT_W    = 12,
  parameter int WIDE_W   = 10,
  parameter int NARROW_W = 8,
  parameter int LINK_W   = 3
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      in_valid,
  input logic [NUM_COMP*OUT_W-1:0] in_pix,
  input logic                      exp_en,
  input logic                      exp_mode,
  input logic [LINK_W-1:0]         link_type,
  input logic                      out_valid,
  input logic [NUM_COMP*OUT_W-1:0] out_pix
);

  localparam int GAP10 = OUT_W - WIDE_W;
  localparam int GAP8  = OUT_W - NARROW_W;

  logic permit;
  assign permit = exp_en &&
                  ((link_type == LINK_W'(2)) || (link_type == LINK_W'(3)) ||
                   (link_type == LINK_W'(4)));

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);  // R2
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);  // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_pix));  // R10

  for (genvar k = 0; k < NUM_COMP; k++) begin : g_comp
    localparam int TOP = k*OUT_W + OUT_W - 1;
    localparam int BOT = k*OUT_W;

    AST_TOP_PASS_TEN: assert property (@(posedge clk) disable iff (rst)
      in_valid && !exp_mode |=> out_pix[TOP -: WIDE_W] == $past(in_pix[TOP -: WIDE_W]));  // R3
    AST_TOP_PASS_EIGHT: assert property (@(posedge clk) disable iff (rst)
      in_valid && exp_mode |=> out_pix[TOP -: NARROW_W] == $past(in_pix[TOP -: NARROW_W]));  // R3
    AST_REPL_TEN: assert property (@(posedge clk) disable iff (rst)
      in_valid && !exp_mode && permit |=> out_pix[BOT +: GAP10] == $past(in_pix[TOP -: GAP10]));  // R4
    AST_REPL_EIGHT: assert property (@(posedge clk) disable iff (rst)
      in_valid && exp_mode && permit |=> out_pix[BOT +: GAP8] == $past(in_pix[TOP -: GAP8]));  // R5
    AST_ZERO_TEN: assert property (@(posedge clk) disable iff (rst)
      in_valid && !exp_mode && !permit |=> out_pix[BOT +: GAP10] == '0);  // R6
    AST_ZERO_EIGHT: assert property (@(posedge clk) disable iff (rst)
      in_valid && exp_mode && !permit |=> out_pix[BOT +: GAP8] == '0);  // R7
  end

endmodule

bind dpx_expander dpx_expander_chk #(
  .NUM_COMP (NUM_COMP),
  .OUT_W    (OUT_W),
  .WIDE_W   (WIDE_W),
  .NARROW_W (NARROW_W),
  .LINK_W   (LINK_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_pix    (in_pix),
  .exp_en    (exp_en),
  .exp_mode  (exp_mode),
  .link_type (link_type),
  .out_valid (out_valid),
  .out_pix   (out_pix)
);

// File: tb/dpx_expander_tb.sv
`timescale 1ns/1ps
module dpx_expander_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [35:0] in_pix;
  logic        exp_en;
  logic        exp_mode;
  logic [2:0]  link_type;
  logic        out_valid;
  logic [35:0] out_pix;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  dpx_expander u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_pix(in_pix),
    .exp_en(exp_en), .exp_mode(exp_mode), .link_type(link_type),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  function automatic logic [11:0] model(input logic [11:0] c, input logic en,
                                        input logic mode, input logic [2:0] link);
    logic ok;
    ok = en && (link == 3'd2 || link == 3'd3 || link == 3'd4);
    if (mode) model = {c[11:4], ok ? c[11:8] : 4'h0};
    else      model = {c[11:2], ok ? c[11:10] : 2'b00};
  endfunction

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one pixel for one cycle, then check the registered result
  task automatic send(input string req, input logic [35:0] pix, input logic en,
                      input logic mode, input logic [2:0] link);
    logic [35:0] exp;
    for (int k = 0; k < 3; k++) exp[k*12 +: 12] = model(pix[k*12 +: 12], en, mode, link);
    @(negedge clk);
    in_valid = 1'b1; in_pix = pix; exp_en = en; exp_mode = mode; link_type = link;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {35'd0, out_valid}, 36'd1);
    check(req, out_pix, exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_pix = '1;
    @(negedge clk);
    @(negedge clk);
    check("R1 out_valid", {35'd0, out_valid}, 36'd0);
    check("R1 out_pix", out_pix, 36'd0);
    rst = 1'b0; in_valid = 1'b0;
  endtask

  task automatic t_mode_eight();
    send("R5 full scale", 36'hFF0_FF0_FF0, 1'b1, 1'b1, 3'd2);
    check("R5 value", out_pix, 36'hFFF_FFF_FFF);
    send("R5 zero", 36'h000_000_000, 1'b1, 1'b1, 3'd3);
    send("R3 R5 junk low", 36'hA5F_3CF_81A, 1'b1, 1'b1, 3'd4);
    check("R5 value", out_pix[11:0], 36'h818);
  endtask

  task automatic t_mode_ten();
    send("R4 full scale", 36'hFFC_FFC_FFC, 1'b1, 1'b0, 3'd3);
    check("R4 value", out_pix, 36'hFFF_FFF_FFF);
    send("R4 pattern", 36'h804_400_C00, 1'b1, 1'b0, 3'd2);
    check("R4 value", out_pix, 36'h806_401_C03);
  endtask

  task automatic t_twelve_bit();
    send("R8 12-bit src", 36'h003_7FF_C01, 1'b1, 1'b0, 3'd4);
    check("R8 value", out_pix, 36'h000_7FD_C03);
  endtask

  task automatic t_link_sweep();
    for (int l = 0; l < 8; l++) begin
      send($sformatf("R6 link %0d mode1", l), 36'hF0F_A5A_C33, 1'b1, 1'b1, 3'(l));
      send($sformatf("R6 link %0d mode0", l), 36'hC03_8FF_4A2, 1'b1, 1'b0, 3'(l));
    end
  endtask

  task automatic t_enable_off();
    send("R7 off mode1 hdmi", 36'hFFF_FFF_FFF, 1'b0, 1'b1, 3'd2);
    check("R7 value", out_pix, 36'hFF0_FF0_FF0);
    send("R7 off mode0 dp", 36'hFFF_FFF_FFF, 1'b0, 1'b0, 3'd3);
    check("R7 value", out_pix, 36'hFFC_FFC_FFC);
  endtask

  task automatic t_components();
    send("R9 distinct comps", 36'h123_9AB_E5F, 1'b1, 1'b1, 3'd3);
    check("R9 value", out_pix, 36'h121_9A9_E5E);
  endtask

  task automatic t_latency();
    @(negedge clk);
    in_valid = 1'b1; in_pix = 36'h400_400_400; exp_en = 1'b1; exp_mode = 1'b0; link_type = 3'd2;
    check("R2 before edge", {35'd0, out_valid}, 36'd0);
    @(negedge clk);
    in_pix = 36'hC00_C00_C00;
    check("R2 first beat", out_pix, 36'h401_401_401);
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 second beat", out_pix, 36'hC03_C03_C03);
    @(negedge clk);
    check("R2 valid drops", {35'd0, out_valid}, 36'd0);
  endtask

  task automatic t_hold();
    send("R10 load", 36'h5A4_5A4_5A4, 1'b1, 1'b0, 3'd2);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_pix = 36'hFFF_000_FFF ^ 36'(i); exp_mode = ~exp_mode; link_type = 3'(i + 3);
      @(negedge clk);
      check("R10 hold", out_pix, 36'h5A5_5A5_5A5);
    end
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_pix = '0; exp_en = 1'b0; exp_mode = 1'b0; link_type = 3'd0;
    t_reset();
    t_mode_eight();
    t_mode_ten();
    t_twelve_bit();
    t_link_sweep();
    t_enable_off();
    t_components();
    t_latency();
    t_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule